// File: doc/BRIEF.md
# Register Renamer with Zeroing-Idiom Detection

This block sits between decode and issue in a small out-of-order core model. Every cycle it can accept one decoded instruction. An instruction names up to two architectural source registers and one architectural destination, and carries a two-bit instruction class. The block looks up the current physical register for each source in an alias table. It takes a fresh physical register for the destination from a FIFO free list and sends out the mapping the destination had before, so that retirement can later return that old register.

A destination is always given a new physical register, whatever its old value was. Later readers of the register therefore depend only on the new producer, and reuse of the same architectural name carries no false dependency. The block also knows when an instruction reads nothing at all. A move reads only its first source. An XOR of a register with itself has no real inputs, so both of its sources are dropped and a flag is raised so that later stages can write zero without executing it. A store-class instruction reads two registers and writes none.

All rename outputs are combinational from the inputs and the current state. State changes on the clock edge at which `in_valid` and `in_ready` are both high.

Top module: `renamer_top`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and `in_ready` is high.
- R2: After reset, destination tags are handed out in ascending order starting at ARCH_REGS, and each is used only once until it is retired.
- R3: A source lookup returns the mapping from before the same instruction's own destination update, so a register that is both source and destination reads its old tag.
- R4: An instruction that reads a register renamed by an earlier accepted instruction receives that earlier instruction's new destination tag.
- R5: `out_pold` carries the physical register that the destination was mapped to just before the instruction was accepted.
- R6: Class 2 (XOR) with both source indices equal is a zeroing idiom. Both source valid bits are low, `out_zero` is high, and a fresh destination is still allocated.
- R7: Class 2 with different source indices reads both sources, and `out_zero` is low.
- R8: Class 1 (move) marks only source 0 valid. Source 1 is ignored.
- R9: Class 3 (store) reads both sources and allocates no destination. `out_pdst_vld` is low, the free list is not consumed, and the alias table is unchanged. Class 0 (ALU) reads both sources and writes the destination.
- R10: `in_ready` is low exactly when the free list is empty. An instruction offered while `in_ready` is low leaves the alias table unchanged.
- R11: A tag presented with `ret_valid` joins the tail of the free list and is handed out after every tag that was already queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Renamer can accept (free list not empty) |
| in_cls | input | 2 | Class: 0 ALU, 1 move, 2 XOR, 3 store |
| in_src0 | input | $clog2(ARCH_REGS) | Architectural source 0 |
| in_src1 | input | $clog2(ARCH_REGS) | Architectural source 1 |
| in_dst | input | $clog2(ARCH_REGS) | Architectural destination |
| out_psrc0 | output | $clog2(PHYS_REGS) | Physical tag of source 0 |
| out_psrc0_vld | output | 1 | Source 0 is a real dependency |
| out_psrc1 | output | $clog2(PHYS_REGS) | Physical tag of source 1 |
| out_psrc1_vld | output | 1 | Source 1 is a real dependency |
| out_pdst | output | $clog2(PHYS_REGS) | Newly allocated destination tag |
| out_pdst_vld | output | 1 | A destination is allocated |
| out_pold | output | $clog2(PHYS_REGS) | Prior mapping of the destination, freed at retire |
| out_zero | output | 1 | Zeroing idiom detected |
| ret_valid | input | 1 | Retire returns a tag |
| ret_tag | input | $clog2(PHYS_REGS) | Physical tag to free |

## Verification
The hardest state to reach is an empty free list while an instruction is still being offered, followed by a retirement that refills the list. Only that sequence shows that a stalled request leaves the mapping alone and that a returned tag waits behind the tags already queued. The stimulus first uses up every initial free tag with a mix of ALU, move, XOR and store instructions. It then retires one tag and uses it, stalls on the empty list, and looks up the stalled register's mapping. Finally it retires another tag to release the stall.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_MOVE  = 2'd1,
    CLS_XOR   = 2'd2,
    CLS_STORE = 2'd3
  } rn_cls_e;
endpackage

// File: rtl/rn_idiom_decode.sv
module rn_idiom_decode #(
  parameter int ARCH_REGS = 8,
  localparam int AW = $clog2(ARCH_REGS)
) (
  input  logic [1:0]    cls,
  input  logic [AW-1:0] src0,
  input  logic [AW-1:0] src1,
  output logic          use_src0,
  output logic          use_src1,
  output logic          use_dst,
  output logic          is_zero
);
  import rn_pkg::*;

  always_comb begin
    use_src0 = 1'b1;
    use_src1 = 1'b1;
    use_dst  = 1'b1;
    is_zero  = 1'b0;
    case (rn_cls_e'(cls))
      CLS_MOVE:  use_src1 = 1'b0;
      CLS_XOR: begin
        if (src0 == src1) begin
          use_src0 = 1'b0;
          use_src1 = 1'b0;
          is_zero  = 1'b1;
        end
      end
      CLS_STORE: use_dst = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd0_idx,
  input  logic [AW-1:0] rd1_idx,
  input  logic [AW-1:0] rdd_idx,
  output logic [PW-1:0] rd0_tag,
  output logic [PW-1:0] rd1_tag,
  output logic [PW-1:0] rdd_tag,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [PW-1:0] wr_tag
);
  logic [PW-1:0] map_q [ARCH_REGS];
  logic [PW-1:0] map_d [ARCH_REGS];

  assign rd0_tag = map_q[rd0_idx];
  assign rd1_tag = map_q[rd1_idx];
  assign rdd_tag = map_q[rdd_idx];

  always_comb begin
    for (int i = 0; i < ARCH_REGS; i++) map_d[i] = map_q[i];
    if (wr_en) map_d[wr_idx] = wr_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
    end else if (wr_en) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= map_d[i];
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int PW    = $clog2(PHYS_REGS),
  localparam int DEPTH = PHYS_REGS,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int INIT  = PHYS_REGS - ARCH_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_tag,
  output logic [PW-1:0] head_tag,
  output logic          empty
);
  logic [PW-1:0] ent_q [DEPTH];
  logic [IW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop, en;

  assign empty    = (cnt_q == '0);
  assign head_tag = ent_q[rd_q];
  assign do_pop   = pop && !empty;
  assign en       = do_pop || push;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (do_pop) rd_d = (rd_q == IW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push)   wr_d = (wr_q == IW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    case ({push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= IW'(INIT % DEPTH);
      cnt_q <= CW'(INIT);
    end else if (en) begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++)
        ent_q[k] <= (k < INIT) ? PW'(ARCH_REGS + k) : '0;
    end else if (push) begin
      ent_q[wr_q] <= push_tag;
    end
  end
endmodule

// File: rtl/renamer_top.sv
module renamer_top #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_cls,
  input  logic [AW-1:0] in_src0,
  input  logic [AW-1:0] in_src1,
  input  logic [AW-1:0] in_dst,
  output logic [PW-1:0] out_psrc0,
  output logic          out_psrc0_vld,
  output logic [PW-1:0] out_psrc1,
  output logic          out_psrc1_vld,
  output logic [PW-1:0] out_pdst,
  output logic          out_pdst_vld,
  output logic [PW-1:0] out_pold,
  output logic          out_zero,
  input  logic          ret_valid,
  input  logic [PW-1:0] ret_tag
);
  logic use_s0, use_s1, use_d, zero;
  logic fl_empty, alloc;
  logic [PW-1:0] head;

  rn_idiom_decode #(.ARCH_REGS(ARCH_REGS)) dec_i (
    .cls(in_cls), .src0(in_src0), .src1(in_src1),
    .use_src0(use_s0), .use_src1(use_s1), .use_dst(use_d), .is_zero(zero)
  );

  assign in_ready = !fl_empty;
  assign alloc    = in_valid && in_ready && use_d;

  rn_alias_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) rat_i (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(in_src0), .rd1_idx(in_src1), .rdd_idx(in_dst),
    .rd0_tag(out_psrc0), .rd1_tag(out_psrc1), .rdd_tag(out_pold),
    .wr_en(alloc), .wr_idx(in_dst), .wr_tag(head)
  );

  rn_free_list #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) fl_i (
    .clk(clk), .rst_n(rst_n),
    .pop(alloc), .push(ret_valid), .push_tag(ret_tag),
    .head_tag(head), .empty(fl_empty)
  );

  assign out_pdst      = head;
  assign out_pdst_vld  = use_d;
  assign out_psrc0_vld = use_s0;
  assign out_psrc1_vld = use_s1;
  assign out_zero      = zero;
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_cls,
  input logic [AW-1:0] in_src0,
  input logic [AW-1:0] in_src1,
  input logic          out_psrc0_vld,
  input logic          out_psrc1_vld,
  input logic [PW-1:0] out_pdst,
  input logic          out_pdst_vld,
  input logic [PW-1:0] out_pold,
  input logic          out_zero,
  input logic          ret_valid
);
  logic [CW-1:0] occ_q;
  logic take;
  assign take = in_valid && in_ready && (in_cls != 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= CW'(PHYS_REGS - ARCH_REGS);
    else if (take || ret_valid)
      occ_q <= occ_q + CW'(ret_valid) - CW'(take);
  end

  AST_READY_TRACKS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (occ_q != '0)) else $error("ready mismatch"); // R10
  AST_ZERO_NO_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
    out_zero |-> (!out_psrc0_vld && !out_psrc1_vld && out_pdst_vld)) else $error("zero idiom"); // R6
  AST_XOR_SAME_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cls == 2'd2 && in_src0 == in_src1) |-> out_zero) else $error("xor idiom"); // R6
  AST_STORE_NO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cls == 2'd3) |-> (!out_pdst_vld && out_psrc0_vld && out_psrc1_vld)) else $error("store dest"); // R9
  AST_MOVE_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cls == 2'd1) |-> (out_psrc0_vld && !out_psrc1_vld)) else $error("move src"); // R8
  AST_DEST_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (take) |-> (out_pdst != out_pold)) else $error("dest reuse"); // R2
endmodule

bind renamer_top rn_checker #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_cls(in_cls), .in_src0(in_src0), .in_src1(in_src1),
  .out_psrc0_vld(out_psrc0_vld), .out_psrc1_vld(out_psrc1_vld),
  .out_pdst(out_pdst), .out_pdst_vld(out_pdst_vld), .out_pold(out_pold),
  .out_zero(out_zero), .ret_valid(ret_valid)
);

// File: tb/renamer_top_tb_top.sv
module renamer_top_tb_top;
  localparam int AW = 3;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, ret_valid;
  logic [1:0] in_cls;
  logic [AW-1:0] in_src0, in_src1, in_dst;
  logic [PW-1:0] out_psrc0, out_psrc1, out_pdst, out_pold, ret_tag;
  logic out_psrc0_vld, out_psrc1_vld, out_pdst_vld, out_zero;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  renamer_top #(.ARCH_REGS(8), .PHYS_REGS(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_src0(in_src0), .in_src1(in_src1), .in_dst(in_dst),
    .out_psrc0(out_psrc0), .out_psrc0_vld(out_psrc0_vld),
    .out_psrc1(out_psrc1), .out_psrc1_vld(out_psrc1_vld),
    .out_pdst(out_pdst), .out_pdst_vld(out_pdst_vld),
    .out_pold(out_pold), .out_zero(out_zero),
    .ret_valid(ret_valid), .ret_tag(ret_tag)
  );

  // {cls, src0, src1, dst, ps0, ps0v, ps1, ps1v, pdst, pdv, pold, zero}
  typedef struct packed {
    logic [1:0] cls; logic [2:0] s0; logic [2:0] s1; logic [2:0] d;
    logic [3:0] ps0; logic ps0v; logic [3:0] ps1; logic ps1v;
    logic [3:0] pd; logic pdv; logic [3:0] po; logic z;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 3'd1, 3'd2, 3'd1, 4'd1,  1'b1, 4'd2,  1'b1, 4'd8,  1'b1, 4'd1, 1'b0}, // R3
    '{2'd0, 3'd1, 3'd1, 3'd3, 4'd8,  1'b1, 4'd8,  1'b1, 4'd9,  1'b1, 4'd3, 1'b0}, // R4
    '{2'd2, 3'd4, 3'd4, 3'd4, 4'd4,  1'b0, 4'd4,  1'b0, 4'd10, 1'b1, 4'd4, 1'b1}, // R6
    '{2'd2, 3'd3, 3'd1, 3'd5, 4'd9,  1'b1, 4'd8,  1'b1, 4'd11, 1'b1, 4'd5, 1'b0}, // R7
    '{2'd1, 3'd4, 3'd2, 3'd6, 4'd10, 1'b1, 4'd2,  1'b0, 4'd12, 1'b1, 4'd6, 1'b0}, // R8
    '{2'd3, 3'd6, 3'd5, 3'd0, 4'd12, 1'b1, 4'd11, 1'b1, 4'd13, 1'b0, 4'd0, 1'b0}, // R9
    '{2'd0, 3'd0, 3'd6, 3'd0, 4'd0,  1'b1, 4'd12, 1'b1, 4'd13, 1'b1, 4'd0, 1'b0}, // R9
    '{2'd0, 3'd1, 3'd0, 3'd1, 4'd8,  1'b1, 4'd13, 1'b1, 4'd14, 1'b1, 4'd8, 1'b0}  // R5
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input int s0, input int s1, input int d);
    in_valid = v; in_cls = c;
    in_src0 = AW'(s0); in_src1 = AW'(s1); in_dst = AW'(d);
  endtask

  task automatic check_vec(input string req, input vec_t e);
    check(req, "ps0v", int'(out_psrc0_vld), int'(e.ps0v));
    if (e.ps0v) check(req, "ps0", int'(out_psrc0), int'(e.ps0));
    check(req, "ps1v", int'(out_psrc1_vld), int'(e.ps1v));
    if (e.ps1v) check(req, "ps1", int'(out_psrc1), int'(e.ps1));
    check(req, "pdv", int'(out_pdst_vld), int'(e.pdv));
    if (e.pdv) begin
      check(req, "pdst", int'(out_pdst), int'(e.pd));
      check(req, "pold", int'(out_pold), int'(e.po));
    end
    check(req, "zero", int'(out_zero), int'(e.z));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ret_valid = 1'b0; ret_tag = '0;
    drive(1'b0, 2'd3, 5, 7, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    // R1: identity mapping and ready after reset
    check("R1", "ready", int'(in_ready), 1);
    check("R1", "ps0", int'(out_psrc0), 5);
    check("R1", "ps1", int'(out_psrc1), 7);
    drive(1'b0, 2'd0, 0, 0, 2);
    #1;
    check("R2", "first pdst", int'(out_pdst), 8);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      drive(1'b1, VECS[i].cls, int'(VECS[i].s0), int'(VECS[i].s1), int'(VECS[i].d));
      #2;
      check_vec($sformatf("R2/vec%0d", i), VECS[i]);
    end

    // R11: retire tag 1, it queues behind 15
    @(negedge clk);
    drive(1'b1, 2'd0, 2, 2, 2);
    ret_valid = 1'b1; ret_tag = 4'd1;
    #2;
    check("R11", "pdst before queued", int'(out_pdst), 15);
    check("R11", "pold", int'(out_pold), 2);
    @(negedge clk);
    ret_valid = 1'b0;
    drive(1'b1, 2'd0, 7, 7, 7);
    #2;
    check("R11", "returned tag", int'(out_pdst), 1);
    check("R11", "pold", int'(out_pold), 7);

    // R10: list empty now, stall
    @(negedge clk);
    drive(1'b1, 2'd0, 1, 1, 1);
    #2;
    check("R10", "ready low", int'(in_ready), 0);
    @(negedge clk);
    drive(1'b1, 2'd3, 1, 7, 0);
    #2;
    check("R10", "map r1 unchanged", int'(out_psrc0), 14);
    check("R10", "map r7", int'(out_psrc1), 1);
    check("R10", "still stalled", int'(in_ready), 0);
    drive(1'b0, 2'd0, 1, 1, 1);
    ret_valid = 1'b1; ret_tag = 4'd3;
    @(negedge clk);
    ret_valid = 1'b0;
    drive(1'b1, 2'd0, 1, 1, 1);
    #2;
    check("R10", "ready after retire", int'(in_ready), 1);
    check("R11", "pdst after refill", int'(out_pdst), 3);
    check("R5", "pold r1", int'(out_pold), 14);
    check("R3", "src reads old", int'(out_psrc0), 14);
    @(negedge clk);
    drive(1'b0, 2'd3, 1, 1, 0);
    #2;
    check("R4", "r1 now new tag", int'(out_psrc0), 3);
    check("R10", "empty again", int'(in_ready), 0);
    finish_run();
  end
endmodule